// File: doc/BRIEF.md
# Link Self-Test Pass Checker

This block sits on the receive side of a serial link that delivers a 24-bit payload word on each recovered pixel clock. It checks that payload during an at-speed self-test. A test enable input arms it. While the enable is high, every qualified received word is compared against an expected word. A local pseudo-random generator produces that expected word, and it must match the generator on the transmit side. Any mismatch is recorded.

The test has no built-in length. A run lasts exactly as long as the enable is held high. When the enable drops, checking stops and a single pass bit shows the verdict. That bit holds its value until the next run starts, a reset is applied, or power-down is asserted. Checking is suspended while the link reports loss of lock, and the pattern generator stalls during that time.

A saturating mismatch counter runs alongside the pass bit. A registered lock status output is also provided, and it does not depend on the test verdict. The system must put the transmitter into test mode first and wait before it raises this block's enable. At the end of the test the system must drop this block's enable before the transmitter leaves test mode.

Top module: `link_bist_checker`

## Requirements
- R1: When `rst_n` is low or `pwr_dn` is high at a clock edge, the next state has `pass_o` = 0, `err_cnt` = 0 and `lock_o` = 0, and the generator is back at its seed.
- R2: At an edge where `bist_en` is high and was low at the previous edge, a new run starts. The counter and `pass_o` clear, the generator is reseeded, and the word present in that same cycle is compared against the seed's word.
- R3: The expected word comes from a 23-bit PRBS with polynomial x^23+x^18+1 and seed 0x5A5A5A. The state s[22:0] is stepped 24 times per word. At step i (0 to 23), b = s[22] XOR s[17], expected bit i = b, and the state becomes {s[21:0], b}.
- R4: A word is compared only at an edge where `bist_en`, `lock_in` and `rx_valid` are all high. The generator advances by one word only on a compared word and stalls otherwise, including while `lock_in` is low.
- R5: `err_cnt` counts the mismatching compared words of the current run and saturates at 65535.
- R6: At the first edge where `bist_en` is low after being high, `pass_o` becomes 1 if the run had no mismatch and 0 otherwise. `pass_o` reads 0 for the whole run.
- R7: While `bist_en` stays low, `pass_o` and `err_cnt` hold their values until a new run, a reset or a power-down.
- R8: `lock_o` is `lock_in` delayed by one clock, and neither mismatches nor the verdict affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down, clears like reset |
| bist_en | input | 1 | Self-test enable; high time sets test length |
| lock_in | input | 1 | Link lock status from clock recovery |
| rx_valid | input | 1 | Received word strobe |
| rx_data | input | 24 | Received payload word |
| pass_o | output | 1 | Latched test verdict |
| lock_o | output | 1 | Registered lock status |
| err_cnt | output | 16 | Saturating mismatch word count |

## Verification
Every result of this block comes from a single register stage. A word, an enable edge, a reset or a lock change applied before clock edge k shows up on `pass_o`, `err_cnt` or `lock_o` just after edge k and not later. The bench drives inputs on the falling edge and reads outputs one nanosecond after the next rising edge, so each check sees the result of exactly the stimulus that caused it. The bench predicts the expected payload with its own PRBS model, which it reseeds at each enable rise and advances only on qualified words.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
   localparam int unsigned DEF_DATA_W   = 24;
   localparam int unsigned DEF_PRBS_LEN = 23;
   localparam int unsigned DEF_PRBS_TAP = 18;
   localparam int unsigned DEF_CNT_W    = 16;
   localparam int unsigned DEF_LANE_W   = 8;

   typedef struct packed {
      logic start;
      logic stop;
      logic check;
   } run_evt_t;
endpackage

// File: rtl/lbc_prbs_gen.sv
module lbc_prbs_gen #(
   parameter int unsigned DATA_W   = 24,
   parameter int unsigned PRBS_LEN = 23,
   parameter int unsigned PRBS_TAP = 18,
   parameter logic [PRBS_LEN-1:0] SEED = 23'h5A5A5A
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              reseed,
   input  logic              advance,
   output logic [DATA_W-1:0] exp_word
);
   localparam int unsigned HI  = PRBS_LEN - 1;
   localparam int unsigned TAP = PRBS_TAP - 1;

   if (PRBS_TAP == 0 || PRBS_TAP >= PRBS_LEN) begin : g_bad_tap
      $error("lbc_prbs_gen: PRBS_TAP must lie in 1..PRBS_LEN-1");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("lbc_prbs_gen: SEED must be nonzero");
   end
   if (DATA_W == 0) begin : g_bad_width
      $error("lbc_prbs_gen: DATA_W must be nonzero");
   end

   logic [PRBS_LEN-1:0] state_q;
   logic [PRBS_LEN-1:0] chain [DATA_W+1];

   assign chain[0] = reseed ? SEED : state_q;

   for (genvar g = 0; g < DATA_W; g++) begin : g_step
      logic fb;
      assign fb          = chain[g][HI] ^ chain[g][TAP];
      assign exp_word[g] = fb;
      assign chain[g+1]  = {chain[g][HI-1:0], fb};
   end

   always_ff @(posedge clk) begin
      if (clr)          state_q <= SEED;
      else if (advance) state_q <= chain[DATA_W];
      else if (reseed)  state_q <= SEED;
   end
endmodule

// File: rtl/lbc_word_cmp.sv
module lbc_word_cmp #(
   parameter int unsigned DATA_W = 24,
   parameter int unsigned LANE_W = 8
) (
   input  logic              check,
   input  logic [DATA_W-1:0] rx_word,
   input  logic [DATA_W-1:0] exp_word,
   output logic              mismatch
);
   localparam int unsigned LANES = DATA_W / LANE_W;

   if (LANE_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("lbc_word_cmp: DATA_W must be a multiple of LANE_W");
   end

   logic [LANES-1:0] lane_bad;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_bad[l] = |(rx_word[l*LANE_W +: LANE_W] ^ exp_word[l*LANE_W +: LANE_W]);
   end

   assign mismatch = check & (|lane_bad);
endmodule

// File: rtl/lbc_verdict.sv
module lbc_verdict
   import link_bist_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             clr,
   input  run_evt_t         evt,
   input  logic             mismatch,
   output logic             pass_o,
   output logic [CNT_W-1:0] err_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W == 0) begin : g_bad_cnt
      $error("lbc_verdict: CNT_W must be nonzero");
   end

   logic err_q;

   always_ff @(posedge clk) begin
      if (clr) begin
         err_q   <= 1'b0;
         err_cnt <= '0;
         pass_o  <= 1'b0;
      end else if (evt.start) begin
         err_q   <= mismatch;
         err_cnt <= {{(CNT_W-1){1'b0}}, mismatch};
         pass_o  <= 1'b0;
      end else begin
         if (mismatch) begin
            err_q <= 1'b1;
            if (err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
         end
         if (evt.stop) pass_o <= ~err_q;
      end
   end
endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker
   import link_bist_pkg::*;
#(
   parameter int unsigned DATA_W   = DEF_DATA_W,
   parameter int unsigned PRBS_LEN = DEF_PRBS_LEN,
   parameter int unsigned PRBS_TAP = DEF_PRBS_TAP,
   parameter logic [PRBS_LEN-1:0] SEED = 23'h5A5A5A,
   parameter int unsigned CNT_W    = DEF_CNT_W,
   parameter int unsigned LANE_W   = DEF_LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              bist_en,
   input  logic              lock_in,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              pass_o,
   output logic              lock_o,
   output logic [CNT_W-1:0]  err_cnt
);
   logic              clr;
   logic              en_q;
   run_evt_t          evt;
   logic [DATA_W-1:0] exp_word;
   logic              mismatch;

   assign clr       = ~rst_n | pwr_dn;
   assign evt.start = bist_en & ~en_q;
   assign evt.stop  = ~bist_en & en_q;
   assign evt.check = bist_en & lock_in & rx_valid;

   always_ff @(posedge clk) begin
      if (clr) begin
         en_q   <= 1'b0;
         lock_o <= 1'b0;
      end else begin
         en_q   <= bist_en;
         lock_o <= lock_in;
      end
   end

   lbc_prbs_gen #(
      .DATA_W  (DATA_W),
      .PRBS_LEN(PRBS_LEN),
      .PRBS_TAP(PRBS_TAP),
      .SEED    (SEED)
   ) u_gen (
      .clk     (clk),
      .clr     (clr),
      .reseed  (evt.start),
      .advance (evt.check),
      .exp_word(exp_word)
   );

   lbc_word_cmp #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W)
   ) u_cmp (
      .check   (evt.check),
      .rx_word (rx_data),
      .exp_word(exp_word),
      .mismatch(mismatch)
   );

   lbc_verdict #(
      .CNT_W(CNT_W)
   ) u_verdict (
      .clk     (clk),
      .clr     (clr),
      .evt     (evt),
      .mismatch(mismatch),
      .pass_o  (pass_o),
      .err_cnt (err_cnt)
   );
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_dn,
   input logic             bist_en,
   input logic             lock_in,
   input logic             pass_o,
   input logic             lock_o,
   input logic [CNT_W-1:0] err_cnt
);
   // R1
   clear_state_chk: assert property (@(posedge clk)
      (!rst_n || pwr_dn) |=> (!pass_o && err_cnt == '0 && !lock_o));

   // R6
   run_pass_low_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      bist_en |=> !pass_o);

   // R6
   pass_rise_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      $rose(pass_o) |-> (!$past(bist_en) && $past(bist_en, 2)));

   // R7
   idle_pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      (!bist_en && !$past(bist_en)) |=> $stable(pass_o));

   // R7
   idle_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      !bist_en |=> $stable(err_cnt));

   // R4
   unlocked_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      (bist_en && $past(bist_en) && !lock_in) |=> $stable(err_cnt));

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      (bist_en && $past(bist_en)) |=>
         (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + CNT_W'(1)));

   // R5
   cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      (bist_en && $past(bist_en) && err_cnt == '1) |=> err_cnt == '1);

   // R8
   lock_high_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      lock_in |=> lock_o);

   // R8
   lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      !lock_in |=> !lock_o);
endmodule

bind link_bist_checker lbc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .pwr_dn (pwr_dn),
   .bist_en(bist_en),
   .lock_in(lock_in),
   .pass_o (pass_o),
   .lock_o (lock_o),
   .err_cnt(err_cnt)
);

// File: tb/link_bist_checker_tb.sv
`timescale 1ns/1ps
module link_bist_checker_tb;
   localparam logic [22:0] SEED_V = 23'h5A5A5A;
   localparam int NV = 18;

   typedef struct packed {
      logic        en;
      logic        lk;
      logic        vld;
      logic [23:0] flip;
      logic [15:0] ecnt;
      logic        epass;
   } vec_t;

   // en lk vld flip ecnt epass
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // idle
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // R2 start, seed word
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // R3
      '{1'b1, 1'b1, 1'b0, 24'hFFFFFF, 16'd0, 1'b0},  // R4 invalid ignored
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // R4 no advance
      '{1'b1, 1'b0, 1'b1, 24'hFFFFFF, 16'd0, 1'b0},  // R4 unlocked
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // R4 stall
      '{1'b0, 1'b1, 1'b1, 24'hFFFFFF, 16'd0, 1'b1},  // R6 pass
      '{1'b0, 1'b1, 1'b1, 24'h000001, 16'd0, 1'b1},  // R7 hold
      '{1'b1, 1'b1, 1'b1, 24'h000001, 16'd1, 1'b0},  // R2 first word bad
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd1, 1'b0},
      '{1'b1, 1'b1, 1'b1, 24'h800000, 16'd2, 1'b0},  // R5
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd2, 1'b0},
      '{1'b0, 1'b1, 1'b1, 24'h000000, 16'd2, 1'b0},  // R6 fail
      '{1'b0, 1'b0, 1'b1, 24'hFFFFFF, 16'd2, 1'b0},  // R7 hold
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},  // R2 restart
      '{1'b1, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b0},
      '{1'b0, 1'b1, 1'b1, 24'h000000, 16'd0, 1'b1}   // R6 pass again
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn = 1'b0;
   logic        bist_en = 1'b0;
   logic        lock_in = 1'b0;
   logic        rx_valid = 1'b0;
   logic [23:0] rx_data = '0;
   logic        pass_o;
   logic        lock_o;
   logic [15:0] err_cnt;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [22:0] m_state = SEED_V;
   logic        m_prev_en = 1'b0;

   always #2 clk = ~clk;

   link_bist_checker u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .bist_en(bist_en),
      .lock_in(lock_in), .rx_valid(rx_valid), .rx_data(rx_data),
      .pass_o(pass_o), .lock_o(lock_o), .err_cnt(err_cnt)
   );

   function automatic void pat(input logic [22:0] s_in,
                               output logic [23:0] w, output logic [22:0] s_out);
      logic [22:0] s;
      logic b;
      s = s_in;
      for (int i = 0; i < 24; i++) begin
         b    = s[22] ^ s[17];
         w[i] = b;
         s    = {s[21:0], b};
      end
      s_out = s;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic lk, input logic vld,
                       input logic [23:0] flip);
      logic [23:0] w;
      logic [22:0] nxt;
      @(negedge clk);
      if (en && !m_prev_en) m_state = SEED_V;
      pat(m_state, w, nxt);
      bist_en  = en;
      lock_in  = lk;
      rx_valid = vld;
      rx_data  = w ^ flip;
      if (en && lk && vld) m_state = nxt;
      m_prev_en = en;
      @(posedge clk);
      #1;
   endtask

   task automatic clear_cycle(input logic use_pd);
      @(negedge clk);
      if (use_pd) pwr_dn = 1'b1; else rst_n = 1'b0;
      bist_en = 1'b0;
      m_prev_en = 1'b0;
      m_state = SEED_V;
      @(posedge clk);
      #1;
      @(negedge clk);
      pwr_dn = 1'b0;
      rst_n  = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "pass after reset", {31'd0, pass_o}, 32'd0);
      chk("R1", "count after reset", {16'd0, err_cnt}, 32'd0);
      chk("R1", "lock after reset", {31'd0, lock_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         step(VECS[v].en, VECS[v].lk, VECS[v].vld, VECS[v].flip);
         chk("R5", $sformatf("count vec %0d", v), {16'd0, err_cnt}, {16'd0, VECS[v].ecnt});
         chk("R6", $sformatf("pass vec %0d", v), {31'd0, pass_o}, {31'd0, VECS[v].epass});
         chk("R8", $sformatf("lock vec %0d", v), {31'd0, lock_o}, {31'd0, VECS[v].lk});
      end

      // R1 power-down clears a held pass
      chk("R1", "pass held before power-down", {31'd0, pass_o}, 32'd1);
      clear_cycle(1'b1);
      chk("R1", "pass after power-down", {31'd0, pass_o}, 32'd0);
      chk("R1", "lock after power-down", {31'd0, lock_o}, 32'd0);

      // R5 saturation
      step(1'b1, 1'b1, 1'b1, 24'hFFFFFF);
      chk("R2", "first bad word counted", {16'd0, err_cnt}, 32'd1);
      for (int k = 0; k < 65540; k++) step(1'b1, 1'b1, 1'b1, 24'h0F0F0F);
      chk("R5", "saturated count", {16'd0, err_cnt}, 32'hFFFF);
      step(1'b0, 1'b1, 1'b1, 24'h0);
      chk("R6", "fail after saturated run", {31'd0, pass_o}, 32'd0);
      chk("R7", "count held after run", {16'd0, err_cnt}, 32'hFFFF);

      // R1 reset clears count
      clear_cycle(1'b0);
      chk("R1", "count after reset", {16'd0, err_cnt}, 32'd0);
      chk("R1", "pass after reset", {31'd0, pass_o}, 32'd0);

      // R3 long clean run follows the PRBS
      for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1, 24'h0);
      chk("R3", "long clean run count", {16'd0, err_cnt}, 32'd0);
      step(1'b0, 1'b1, 1'b1, 24'h0);
      chk("R6", "long clean run pass", {31'd0, pass_o}, 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule